// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block sits in an always-on domain between the shared peripheral interrupt lines and a downstream interrupt controller. It handles 128 level-sensitive shared interrupts. The lines are passed on to the controller unchanged at all times. Each of two CPUs owns three 128-bit enable sets, each held as four 32-bit banks:

- a live set, used while the CPU runs;
- a secure set, which always takes part in wake decisions;
- a suspend set, which takes the place of the live set while the CPU is in standby.

A CPU enters standby by raising its idle request. The block first synchronizes the interrupt lines. It then acknowledges the request only when no interrupt is pending under that CPU's suspend and secure enables. If such an interrupt is pending at entry, or arrives later, the block withholds or drops the acknowledge and raises that CPU's wake output instead. The live set is never overwritten. Once the request falls, it governs the CPU again at once.

Software reaches all the banks through a simple 32-bit valid/ready register port. Run-time masking goes to the live banks. Wake sources meant for suspend go to the separate suspend banks. Each access is therefore independent of whether an interrupt happens to fire during the suspend sequence.

Top module: `wake_gen`

## Requirements
- R1: After reset every enable bit of every set for both CPUs reads as zero, and `idle_ack` and `wake` are low.
- R2: `irq_fwd` equals `irq_in` combinationally in every state, whatever the enables hold.
- R3: The register map uses byte addresses. CPU c has base c*0x400. Its live bank b is at base+0x10+4b, its secure bank b at base+0x20+4b, and its suspend bank b at base+0x30+4b. Bit i of bank b is interrupt 32b+i. A read accepted on one edge returns its data with `bus_rvalid` high after the next edge.
- R4: Reads of any other address, including misaligned addresses and addresses with bit 11 set, return zero. Writes to those addresses change no register.
- R5: Interrupts pass through a two-flop synchronizer. When `idle_req[c]` rises and no interrupt is pending under CPU c's suspend|secure enables, `idle_ack[c]` goes high on the second edge after the rise.
- R6: While CPU c is in standby, its wake decision uses suspend|secure enables only, and its live bits have no effect. Outside standby it uses live|secure enables. The live banks keep their contents through standby.
- R7: If an interrupt is pending under suspend|secure enables at standby entry, `idle_ack[c]` is never raised and `wake[c]` rises on the second edge after the request.
- R8: If such an interrupt arrives while acknowledged, then one edge after the synchronized level becomes visible, `idle_ack[c]` falls and `wake[c]` rises. `wake[c]` then holds while the request stays high.
- R9: One edge after `idle_req[c]` falls, `idle_ack[c]` is low. `wake[c]` then follows the live|secure pending state again.
- R10: Outside standby, `wake[c]` is high one edge after a synchronized interrupt is pending under CPU c's live|secure enables. CPUs are independent of each other.
- R11: `idle_ack[c]` and `wake[c]` are never high together, and `idle_ack[c]` is high only if `idle_req[c]` was high on the previous edge.
- R12: `bus_ready` is always high, and every write takes effect on the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 128 | Shared interrupt lines, level sensitive |
| irq_fwd | output | 128 | Lines forwarded to the downstream controller |
| idle_req | input | 2 | Per-CPU standby idle request |
| idle_ack | output | 2 | Per-CPU idle acknowledge |
| wake | output | 2 | Per-CPU wakeup |
| bus_valid | input | 1 | Register access valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |

## Verification
The assertions check the following on every cycle:

- acknowledge and wake are mutually exclusive;
- acknowledge is present only behind a held request, and it is never raised in less than two edges;
- acknowledge clears in one edge once the request drops;
- every read gets exactly one response.

Only the bench scenarios can show the rest, because each depends on register contents, synchronizer latency and enable-set selection:

- that the suspend set replaces the live set during standby, and that the live set returns afterwards;
- that secure enables count in both modes;
- that a late interrupt revokes an acknowledge;
- that unmapped writes alias nothing.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
    localparam int NUM_CPU     = 2;
    localparam int NUM_IRQ     = 128;
    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 12;
    localparam int CPU_SHIFT   = 10;
    localparam int NUM_BANK    = NUM_IRQ / WORD_W;
    localparam int CPU_IDX_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int BANK_IDX_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
    localparam int GRP_W       = CPU_SHIFT - 4;

    typedef enum logic [1:0] {
        SET_NONE = 2'd0,
        SET_LIVE = 2'd1,
        SET_SEC  = 2'd2,
        SET_SUSP = 2'd3
    } set_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STBY = 2'd1,
        ST_ACK  = 2'd2,
        ST_WAKE = 2'd3
    } pwr_e;

    typedef struct packed {
        logic                  hit;
        logic [CPU_IDX_W-1:0]  cpu;
        set_e                  set;
        logic [BANK_IDX_W-1:0] bank;
    } acc_t;

    function automatic acc_t decode_addr(input logic [ADDR_W-1:0] a);
        acc_t r;
        logic [GRP_W-1:0] grp;
        r      = '0;
        grp    = a[CPU_SHIFT-1:4];
        r.cpu  = a[CPU_SHIFT +: CPU_IDX_W];
        r.bank = a[2 +: BANK_IDX_W];
        if (a[ADDR_W-1:CPU_SHIFT+CPU_IDX_W] == '0 && a[1:0] == 2'b00 &&
            int'(r.cpu) < NUM_CPU && int'(r.bank) < NUM_BANK) begin
            case (grp)
                GRP_W'(1): begin r.hit = 1'b1; r.set = SET_LIVE; end
                GRP_W'(2): begin r.hit = 1'b1; r.set = SET_SEC;  end
                GRP_W'(3): begin r.hit = 1'b1; r.set = SET_SUSP; end
                default:   r.hit = 1'b0;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/wkg_sync.sv
module wkg_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/wkg_regs.sv
module wkg_regs
    import wkg_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_valid,
    input  logic                             bus_write,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [WORD_W-1:0]                bus_wdata,
    output logic                             bus_rvalid,
    output logic [WORD_W-1:0]                bus_rdata,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0]  live_en,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0]  sec_en,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0]  susp_en
);
    acc_t              acc;
    logic [WORD_W-1:0] rd_word;

    assign acc = decode_addr(bus_addr);

    always_comb begin
        rd_word = '0;
        if (acc.hit) begin
            case (acc.set)
                SET_LIVE: rd_word = live_en[acc.cpu][acc.bank*WORD_W +: WORD_W];
                SET_SEC:  rd_word = sec_en[acc.cpu][acc.bank*WORD_W +: WORD_W];
                SET_SUSP: rd_word = susp_en[acc.cpu][acc.bank*WORD_W +: WORD_W];
                default:  rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_en    <= '0;
            sec_en     <= '0;
            susp_en    <= '0;
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) begin
                bus_rdata <= rd_word;
            end
            if (bus_valid && bus_write && acc.hit) begin
                case (acc.set)
                    SET_LIVE: live_en[acc.cpu][acc.bank*WORD_W +: WORD_W] <= bus_wdata;
                    SET_SEC:  sec_en[acc.cpu][acc.bank*WORD_W +: WORD_W]  <= bus_wdata;
                    SET_SUSP: susp_en[acc.cpu][acc.bank*WORD_W +: WORD_W] <= bus_wdata;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/wkg_cpu_fsm.sv
module wkg_cpu_fsm
    import wkg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               idle_req,
    input  logic [NUM_IRQ-1:0] irq_s,
    input  logic [NUM_IRQ-1:0] live_en,
    input  logic [NUM_IRQ-1:0] sec_en,
    input  logic [NUM_IRQ-1:0] susp_en,
    output logic               idle_ack,
    output logic               wake
);
    pwr_e st, st_n;
    logic pend_live, pend_susp;

    // Secure enables count in both modes; the suspend set stands in for the live set in standby.
    assign pend_live = |(irq_s & (live_en | sec_en));
    assign pend_susp = |(irq_s & (susp_en | sec_en));

    always_comb begin
        st_n = st;
        case (st)
            ST_RUN:  if (idle_req) st_n = ST_STBY;
            ST_STBY: begin
                if (!idle_req)      st_n = ST_RUN;
                else if (pend_susp) st_n = ST_WAKE;
                else                st_n = ST_ACK;
            end
            ST_ACK: begin
                if (!idle_req)      st_n = ST_RUN;
                else if (pend_susp) st_n = ST_WAKE;
            end
            ST_WAKE: if (!idle_req) st_n = ST_RUN;
            default: st_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_RUN;
            idle_ack <= 1'b0;
            wake     <= 1'b0;
        end else begin
            st       <= st_n;
            idle_ack <= (st_n == ST_ACK);
            wake     <= (st_n == ST_WAKE) || (st_n == ST_RUN && pend_live);
        end
    end
endmodule

// File: rtl/wake_gen.sv
module wake_gen
    import wkg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic [NUM_IRQ-1:0] irq_fwd,
    input  logic [NUM_CPU-1:0] idle_req,
    output logic [NUM_CPU-1:0] idle_ack,
    output logic [NUM_CPU-1:0] wake,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic               bus_ready,
    output logic               bus_rvalid,
    output logic [WORD_W-1:0]  bus_rdata
);
    logic [NUM_IRQ-1:0]              irq_s;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0] live_en, sec_en, susp_en;

    assign irq_fwd   = irq_in;
    assign bus_ready = 1'b1;

    wkg_sync #(.W(NUM_IRQ)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (irq_s)
    );

    wkg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .live_en    (live_en),
        .sec_en     (sec_en),
        .susp_en    (susp_en)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        wkg_cpu_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .idle_req (idle_req[c]),
            .irq_s    (irq_s),
            .live_en  (live_en[c]),
            .sec_en   (sec_en[c]),
            .susp_en  (susp_en[c]),
            .idle_ack (idle_ack[c]),
            .wake     (wake[c])
        );
    end
endmodule

// File: rtl/wake_gen_chk.sv
module wake_gen_chk
    import wkg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_CPU-1:0] idle_req,
    input logic [NUM_CPU-1:0] idle_ack,
    input logic [NUM_CPU-1:0] wake,
    input logic               bus_valid,
    input logic               bus_write,
    input logic               bus_rvalid
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
        a_r11_ack_wake_excl: assert property (@(posedge clk) disable iff (rst)
            !(idle_ack[c] && wake[c]));
        a_r11_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
            idle_ack[c] |-> $past(idle_req[c]));
        a_r5_ack_min_latency: assert property (@(posedge clk) disable iff (rst)
            $rose(idle_ack[c]) |-> ($past(idle_req[c], 1) && $past(idle_req[c], 2)));
        a_r9_ack_drop: assert property (@(posedge clk) disable iff (rst)
            (idle_ack[c] && !idle_req[c]) |=> !idle_ack[c]);
    end

    a_r3_read_resp: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rvalid);
    a_r3_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind wake_gen wake_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .idle_req   (idle_req),
    .idle_ack   (idle_ack),
    .wake       (wake),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_rvalid (bus_rvalid)
);

// File: tb/wake_gen_test.sv
`timescale 1ns/1ps
module wake_gen_test;
    import wkg_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst;
    logic [NUM_IRQ-1:0] irq_in, irq_fwd;
    logic [NUM_CPU-1:0] idle_req, idle_ack, wake;
    logic               bus_valid, bus_write, bus_ready, bus_rvalid;
    logic [ADDR_W-1:0]  bus_addr;
    logic [WORD_W-1:0]  bus_wdata, bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    wake_gen uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        chk({tag, " rvalid"}, 32'(bus_rvalid), 32'd1);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic t_reset;
        chk("R1 ack", 32'(idle_ack), 0);
        chk("R1 wake", 32'(wake), 0);
        chk("R12 ready", 32'(bus_ready), 1);
        rd("R1 cpu0 live bank0", 12'h010, 0);
        rd("R1 cpu0 secure bank3", 12'h02C, 0);
        rd("R1 cpu1 live bank0", 12'h410, 0);
        rd("R1 cpu1 suspend bank3", 12'h43C, 0);
    endtask

    task automatic t_regmap;
        wr(12'h414, 32'hA5A5_0001);
        wr(12'h038, 32'h0000_1234);
        wr(12'h024, 32'h0F0F_0F0F);
        rd("R3 cpu1 live bank1", 12'h414, 32'hA5A5_0001);
        rd("R3 cpu0 live bank1 untouched", 12'h014, 0);
        rd("R3 cpu0 suspend bank2", 12'h038, 32'h0000_1234);
        rd("R3 cpu0 secure bank1", 12'h024, 32'h0F0F_0F0F);
        wr(12'h414, 0); wr(12'h038, 0); wr(12'h024, 0);
        rd("R3 cleared", 12'h414, 0);
    endtask

    task automatic t_unmapped;
        wr(12'h810, 32'hFFFF_FFFF);
        wr(12'h011, 32'hFFFF_FFFF);
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        rd("R4 read 0x810", 12'h810, 0);
        rd("R4 read 0x040", 12'h040, 0);
        rd("R4 read 0x011", 12'h011, 0);
        rd("R4 no alias 0x010", 12'h010, 0);
        rd("R4 no alias 0x410", 12'h410, 0);
        rd("R4 no alias 0x030", 12'h030, 0);
    endtask

    task automatic t_active;
        wr(12'h010, 32'h0000_0008);
        @(negedge clk);
        irq_in[3] = 1'b1;
        #1;
        chk("R2 forward same cycle", 32'(irq_fwd === irq_in), 1);
        cyc(4);
        chk("R10 cpu0 live wake", 32'(wake[0]), 1);
        chk("R10 cpu1 not woken", 32'(wake[1]), 0);
    endtask

    task automatic t_standby_clean;
        idle_req[0] = 1'b1;
        cyc(1);
        chk("R5 ack not yet", 32'(idle_ack[0]), 0);
        chk("R6 live ignored at entry", 32'(wake[0]), 0);
        cyc(1);
        chk("R5 ack after two edges", 32'(idle_ack[0]), 1);
        chk("R6 live enable no wake in standby", 32'(wake[0]), 0);
        rd("R6 live retained", 12'h010, 32'h0000_0008);
        chk("R2 forward in standby", 32'(irq_fwd[3]), 1);
        idle_req[0] = 1'b0;
        cyc(1);
        chk("R9 ack drops", 32'(idle_ack[0]), 0);
        chk("R9 live restored wake", 32'(wake[0]), 1);
        irq_in[3] = 1'b0;
        wr(12'h010, 0);
        cyc(4);
        chk("R10 wake clears", 32'(wake[0]), 0);
    endtask

    task automatic t_pending_entry;
        wr(12'h034, 32'h0000_0020);
        irq_in[37] = 1'b1;
        cyc(4);
        chk("R6 suspend set unused when running", 32'(wake[0]), 0);
        idle_req[0] = 1'b1;
        cyc(1);
        chk("R7 no ack at entry", 32'(idle_ack[0]), 0);
        cyc(1);
        chk("R7 wake at entry", 32'(wake[0]), 1);
        chk("R11 no ack with wake", 32'(idle_ack[0]), 0);
        cyc(2);
        chk("R7 wake held", 32'(wake[0]), 1);
        idle_req[0] = 1'b0;
        cyc(1);
        chk("R9 wake clears on exit", 32'(wake[0]), 0);
        chk("R9 ack low on exit", 32'(idle_ack[0]), 0);
        irq_in[37] = 1'b0;
        cyc(3);
    endtask

    task automatic t_late;
        idle_req[0] = 1'b1;
        cyc(2);
        chk("R8 acked before irq", 32'(idle_ack[0]), 1);
        irq_in[37] = 1'b1;
        cyc(2);
        chk("R8 ack holds during sync", 32'(idle_ack[0]), 1);
        cyc(1);
        chk("R8 ack revoked", 32'(idle_ack[0]), 0);
        chk("R8 wake raised", 32'(wake[0]), 1);
        idle_req[0] = 1'b0;
        irq_in[37] = 1'b0;
        cyc(1);
        wr(12'h034, 0);
        cyc(3);
    endtask

    task automatic t_secure;
        wr(12'h02C, 32'h8000_0000);
        irq_in[127] = 1'b1;
        cyc(4);
        chk("R6 secure wakes when running", 32'(wake[0]), 1);
        idle_req[0] = 1'b1;
        cyc(2);
        chk("R6 secure wakes in standby", 32'(wake[0]), 1);
        chk("R6 secure no ack", 32'(idle_ack[0]), 0);
        idle_req[0] = 1'b0;
        irq_in[127] = 1'b0;
        wr(12'h02C, 0);
        cyc(4);
    endtask

    task automatic t_indep;
        wr(12'h410, 32'h0000_0001);
        wr(12'h430, 32'h0000_0001);
        irq_in[0] = 1'b1;
        cyc(4);
        chk("R10 cpu1 wake", 32'(wake[1]), 1);
        chk("R10 cpu0 quiet", 32'(wake[0]), 0);
        idle_req = 2'b11;
        cyc(2);
        chk("R10 cpu0 acks", 32'(idle_ack[0]), 1);
        chk("R10 cpu0 no wake", 32'(wake[0]), 0);
        chk("R10 cpu1 wakes in standby", 32'(wake[1]), 1);
        chk("R11 cpu1 no ack", 32'(idle_ack[1]), 0);
        idle_req = 2'b00;
        cyc(1);
        chk("R9 both acks low", 32'(idle_ack), 0);
        irq_in[0] = 1'b0;
        cyc(3);
    endtask

    initial begin
        rst = 1; irq_in = '0; idle_req = '0;
        bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        cyc(3);
        rst = 0;
        cyc(1);
        t_reset();
        t_regmap();
        t_unmapped();
        t_active();
        t_standby_clean();
        t_pending_entry();
        t_late();
        t_secure();
        t_indep();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule